// File: doc/BRIEF.md
# Round-Robin Channel Scan Read Port

This block is the hardware-configured readout path for a set of serial receive channels. An external scanning device reads the captured words without ever writing a register. A free-running modulo counter steps through the channels, one per clock. Its value is shown on a channel-number output, so the reader always knows which channel is on offer. A freeze input stops the stepping, so the reader can stay on one channel.

When the reader asserts select, a registered 8-bit bus carries one byte of the scanned channel's last accepted word. The two-bit byte address picks the byte: code 3 returns the label byte, and codes 0, 1 and 2 return the three data bytes. For a consistent message, the reader should keep select asserted through the label read and at least the first data-byte read. While select is asserted, the scanned channel refuses new words, so the label and data belong to the same word. The lock times out after a bounded number of clocks, so a reader that stalls cannot block a channel for good.

The receive channels are modelled as simple word registers. The block also produces each channel's gap-detection threshold from a two-bit speed strap. Channels below the strap value get the short, high-speed threshold, and all other channels get the long one.

Top module: `rr_scan_port`

## Requirements
- R1: During reset, `chan_id` is 0, `bus_oe` is 0 and `bus_data` is 0.
- R2: While `scan_freeze` is low, `chan_id` advances by one on every clock and wraps from NCH-1 to 0.
- R3: While `scan_freeze` is high, `chan_id` holds its value.
- R4: When `sel` and `byte_addr` are sampled with `sel`=1 and `byte_addr`=3, the next clock drives `bus_oe`=1 and puts word bits [7:0] (the label) of the channel then shown on `chan_id` onto `bus_data`.
- R5: With `sel`=1, `byte_addr` codes 0, 1 and 2 return word bits [15:8], [23:16] and [31:24] respectively, with the same one-clock latency.
- R6: A clock that samples `sel`=0 drives `bus_oe`=0 and `bus_data`=0.
- R7: A pulse on `word_valid[i]` stores the 32-bit slice i of `word_in` as channel i's word, unless that channel is locked.
- R8: While `sel` is high, the channel shown on `chan_id` discards incoming words. Other channels still accept theirs.
- R9: The lock lasts for the first HOLD_MAX (30) clocks that sample `sel` high without a break. A word sampled on clock HOLD_MAX+1 or later is accepted.
- R10: `gap_limit` slice i (7 bits) is 5 when i < `speed_strap` and 32 otherwise, one clock after the strap is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_freeze | input | 1 | Holds the scan counter when high |
| sel | input | 1 | Read select from the scanning device, active high |
| byte_addr | input | 2 | Byte address: 3 = label, 0..2 = data bytes |
| speed_strap | input | 2 | Number of high-speed channels, counted from channel 0 |
| word_valid | input | 4 | One load strobe per receive channel |
| word_in | input | 128 | Received words, channel i in bits [32i+31:32i] |
| chan_id | output | 2 | Channel currently scanned |
| bus_data | output | 8 | Registered read data |
| bus_oe | output | 1 | Read bus drive enable |
| gap_limit | output | 28 | Gap threshold per channel, 7 bits each |

## Verification
A wrong scan count shows up on `chan_id` in the first sample after the fault, and every later read returns a byte from the wrong channel. A wrong byte mux or a lock that is never released corrupts `bus_data` one clock after the address is sampled. The bench sweeps every channel against every byte address. A lock that releases early or late changes the word seen on the next read. The bench therefore probes both sides of the HOLD_MAX boundary, one clock apart. A bad strap decode appears on `gap_limit` one clock after the strap changes, and the bench checks all four strap codes for every channel.

// File: rtl/rr_scan_pkg.sv
package rr_scan_pkg;
  // Byte index inside a word for a given read address: the top address
  // returns the label (byte 0), the others return data bytes 1..n-1.
  function automatic int unsigned byte_index(input int unsigned addr,
                                             input int unsigned nbytes);
    return (addr == nbytes - 1) ? 0 : addr + 1;
  endfunction
endpackage

// File: rtl/rr_scan_counter.sv
module rr_scan_counter #(
  parameter int NCH = 4,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hold,
  output logic [CH_W-1:0] idx,
  output logic [CH_W-1:0] idx_nxt
);
  always_comb begin
    if (hold)                         idx_nxt = idx;
    else if (idx == CH_W'(NCH - 1))   idx_nxt = '0;
    else                              idx_nxt = idx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) idx <= '0;
    else     idx <= idx_nxt;
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(idx));
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    !hold |=> (idx == (($past(idx) == CH_W'(NCH - 1)) ? '0 : $past(idx) + 1'b1)));
endmodule

// File: rtl/rr_scan_hold.sv
module rr_scan_hold #(
  parameter int HOLD_MAX = 30,
  localparam int HC_W = $clog2(HOLD_MAX + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic sel,
  output logic active
);
  logic [HC_W-1:0] held;

  always_ff @(posedge clk) begin
    if (rst || !sel)                     held <= '0;
    else if (held != HC_W'(HOLD_MAX))    held <= held + 1'b1;
  end

  assign active = sel && (held < HC_W'(HOLD_MAX));

  p_sat_r9: assert property (@(posedge clk) disable iff (rst)
    held <= HC_W'(HOLD_MAX));
  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    !sel |=> (held == '0));
endmodule

// File: rtl/rr_scan_chan.sv
module rr_scan_chan #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              lock,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] word_q
);
  always_ff @(posedge clk) begin
    if (rst)               word_q <= '0;
    else if (load && !lock) word_q <= word_in;
  end

  p_locked_r8: assert property (@(posedge clk) disable iff (rst)
    lock |=> $stable(word_q));
  p_load_r7: assert property (@(posedge clk) disable iff (rst)
    (load && !lock) |=> (word_q == $past(word_in)));
endmodule

// File: rtl/rr_scan_gap.sv
module rr_scan_gap #(
  parameter int NCH      = 4,
  parameter int STRAP_W  = 2,
  parameter int GAP_W    = 7,
  parameter int GAP_FAST = 5,
  parameter int GAP_SLOW = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [STRAP_W-1:0]   strap,
  output logic [NCH*GAP_W-1:0] limit
);
  for (genvar i = 0; i < NCH; i++) begin : g_lim
    always_ff @(posedge clk) begin
      if (rst)                     limit[i*GAP_W +: GAP_W] <= GAP_W'(GAP_SLOW);
      else if (i < int'(strap))    limit[i*GAP_W +: GAP_W] <= GAP_W'(GAP_FAST);
      else                         limit[i*GAP_W +: GAP_W] <= GAP_W'(GAP_SLOW);
    end

    p_legal_r10: assert property (@(posedge clk) disable iff (rst)
      (limit[i*GAP_W +: GAP_W] == GAP_W'(GAP_FAST)) ||
      (limit[i*GAP_W +: GAP_W] == GAP_W'(GAP_SLOW)));
  end

  // The last channel can never be counted as fast by a strap of this width
  if (NCH > (1 << STRAP_W) - 1) begin : g_top_slow
    p_top_slow_r10: assert property (@(posedge clk) disable iff (rst)
      limit[(NCH-1)*GAP_W +: GAP_W] == GAP_W'(GAP_SLOW));
  end
endmodule

// File: rtl/rr_scan_port.sv
module rr_scan_port #(
  parameter int NCH      = 4,
  parameter int WORD_W   = 32,
  parameter int BYTE_W   = 8,
  parameter int HOLD_MAX = 30,
  parameter int STRAP_W  = 2,
  parameter int GAP_W    = 7,
  parameter int GAP_FAST = 5,
  parameter int GAP_SLOW = 32,
  localparam int CH_W    = $clog2(NCH),
  localparam int NBYTES  = WORD_W / BYTE_W,
  localparam int ADDR_W  = $clog2(NBYTES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scan_freeze,
  input  logic                  sel,
  input  logic [ADDR_W-1:0]     byte_addr,
  input  logic [STRAP_W-1:0]    speed_strap,
  input  logic [NCH-1:0]        word_valid,
  input  logic [NCH*WORD_W-1:0] word_in,
  output logic [CH_W-1:0]       chan_id,
  output logic [BYTE_W-1:0]     bus_data,
  output logic                  bus_oe,
  output logic [NCH*GAP_W-1:0]  gap_limit
);
  import rr_scan_pkg::*;

  logic [CH_W-1:0]   idx_nxt;
  logic              hold_on;
  logic [NCH-1:0]    lock;
  logic [WORD_W-1:0] words [NCH];
  logic [WORD_W-1:0] word_pick;
  logic [ADDR_W-1:0] bidx;

  rr_scan_counter #(.NCH(NCH)) u_cnt (
    .clk(clk), .rst(rst), .hold(scan_freeze), .idx(chan_id), .idx_nxt(idx_nxt)
  );

  rr_scan_hold #(.HOLD_MAX(HOLD_MAX)) u_hold (
    .clk(clk), .rst(rst), .sel(sel), .active(hold_on)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign lock[i] = hold_on && (chan_id == CH_W'(i));
    rr_scan_chan #(.WORD_W(WORD_W)) u_chan (
      .clk(clk), .rst(rst), .load(word_valid[i]), .lock(lock[i]),
      .word_in(word_in[i*WORD_W +: WORD_W]), .word_q(words[i])
    );
  end

  rr_scan_gap #(
    .NCH(NCH), .STRAP_W(STRAP_W), .GAP_W(GAP_W),
    .GAP_FAST(GAP_FAST), .GAP_SLOW(GAP_SLOW)
  ) u_gap (
    .clk(clk), .rst(rst), .strap(speed_strap), .limit(gap_limit)
  );

  // Read the channel the counter moves to, so bus and chan_id update together
  assign word_pick = words[idx_nxt];
  assign bidx      = ADDR_W'(byte_index(32'(byte_addr), NBYTES));

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_oe   <= 1'b0;
      bus_data <= '0;
    end else begin
      bus_oe   <= sel;
      bus_data <= sel ? word_pick[bidx*BYTE_W +: BYTE_W] : '0;
    end
  end

  p_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !sel |=> (!bus_oe && bus_data == '0));
  p_drive_r4: assert property (@(posedge clk) disable iff (rst)
    sel |=> bus_oe);
  p_one_lock_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lock));
endmodule

// File: tb/test_rr_scan_port.sv
module test_rr_scan_port;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         scan_freeze = 1'b0;
  logic         sel = 1'b0;
  logic [1:0]   byte_addr = '0;
  logic [1:0]   speed_strap = '0;
  logic [3:0]   word_valid = '0;
  logic [127:0] word_in = '0;
  logic [1:0]   chan_id;
  logic [7:0]   bus_data;
  logic         bus_oe;
  logic [27:0]  gap_limit;

  int checks = 0;
  int errors = 0;
  logic [31:0] mem [4];

  always #4 clk = ~clk;

  rr_scan_port i_rr_scan_port (
    .clk(clk), .rst(rst), .scan_freeze(scan_freeze), .sel(sel),
    .byte_addr(byte_addr), .speed_strap(speed_strap), .word_valid(word_valid),
    .word_in(word_in), .chan_id(chan_id), .bus_data(bus_data),
    .bus_oe(bus_oe), .gap_limit(gap_limit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pattern(input int c, input int gen);
    return 32'h13579BDF ^ (32'(c) * 32'h11111111) ^ (32'(gen) * 32'h0204_0810);
  endfunction

  function automatic logic [7:0] exp_byte(input logic [31:0] w, input int a);
    return (a == 3) ? w[7:0] : w[8*a+8 +: 8];
  endfunction

  task automatic goto(input int c);
    scan_freeze = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (chan_id == 2'(c)) begin
        scan_freeze = 1'b1;
        break;
      end
    end
    chk("R2 reach", 32'(chan_id), 32'(c));
  endtask

  task automatic load(input int c, input logic [31:0] w);
    @(negedge clk);
    word_valid[c] = 1'b1;
    word_in[c*32 +: 32] = w;
    @(negedge clk);
    word_valid = '0;
  endtask

  task automatic read(input int a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    sel = 1'b1;
    byte_addr = 2'(a);
    @(negedge clk);
    d = bus_data;
    oe = bus_oe;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic       oe;
    logic [1:0] v;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 chan_id", 32'(chan_id), 0);
    chk("R1 bus_oe", 32'(bus_oe), 0);
    chk("R1 bus_data", 32'(bus_data), 0);
    rst = 1'b0;

    // R2: free-running scan with wrap
    @(negedge clk);
    v = chan_id;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk("R2 step", 32'(chan_id), 32'(2'(v + 2'd1)));
      v = chan_id;
    end

    // R3: frozen scan
    scan_freeze = 1'b1;
    v = chan_id;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R3 hold", 32'(chan_id), 32'(v));
    end

    // R10: every strap code against every channel
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      speed_strap = 2'(s);
      @(negedge clk);
      for (int c = 0; c < 4; c++)
        chk("R10 gap", 32'(gap_limit[c*7 +: 7]), (c < s) ? 5 : 32);
    end

    // R7, R4, R5, R6: load all channels, read every byte of every channel
    for (int c = 0; c < 4; c++) begin
      mem[c] = pattern(c, 0);
      load(c, mem[c]);
    end
    for (int c = 0; c < 4; c++) begin
      goto(c);
      for (int a = 0; a < 4; a++) begin
        read(a, d, oe);
        chk("R4 oe", 32'(oe), 1);
        chk((a == 3) ? "R4 label" : "R5 data", 32'(d), 32'(exp_byte(mem[c], a)));
      end
      @(negedge clk);
      sel = 1'b0;
      @(negedge clk);
      chk("R6 oe", 32'(bus_oe), 0);
      chk("R6 data", 32'(bus_data), 0);
    end

    // R8: the scanned channel is locked, the others are not
    goto(1);
    read(3, d, oe);
    @(negedge clk);
    word_valid = 4'b1010;
    word_in[1*32 +: 32] = pattern(1, 1);
    word_in[3*32 +: 32] = pattern(3, 1);
    @(negedge clk);
    word_valid = '0;
    read(3, d, oe);
    chk("R8 locked label", 32'(d), 32'(exp_byte(mem[1], 3)));
    read(1, d, oe);
    chk("R8 locked data", 32'(d), 32'(exp_byte(mem[1], 1)));
    mem[3] = pattern(3, 1);
    @(negedge clk);
    sel = 1'b0;
    goto(3);
    read(3, d, oe);
    chk("R8 other channel", 32'(d), 32'(exp_byte(mem[3], 3)));
    @(negedge clk);
    sel = 1'b0;

    // R7: unlocked load after the lock is gone
    goto(1);
    mem[1] = pattern(1, 2);
    load(1, mem[1]);
    read(2, d, oe);
    chk("R7 reload", 32'(d), 32'(exp_byte(mem[1], 2)));
    @(negedge clk);
    sel = 1'b0;

    // R9: word sampled on the last locked clock is dropped
    goto(2);
    @(negedge clk);
    sel = 1'b1;
    byte_addr = 2'd3;
    repeat (29) @(posedge clk);
    @(negedge clk);
    word_valid[2] = 1'b1;
    word_in[2*32 +: 32] = pattern(2, 3);
    @(negedge clk);
    word_valid = '0;
    @(negedge clk);
    chk("R9 last locked", 32'(bus_data), 32'(exp_byte(mem[2], 3)));
    chk("R9 chan kept", 32'(chan_id), 2);
    sel = 1'b0;

    // R9: word sampled on the first clock past the limit is taken
    @(negedge clk);
    sel = 1'b1;
    repeat (30) @(posedge clk);
    @(negedge clk);
    word_valid[2] = 1'b1;
    mem[2] = pattern(2, 4);
    word_in[2*32 +: 32] = mem[2];
    @(negedge clk);
    word_valid = '0;
    @(negedge clk);
    chk("R9 released", 32'(bus_data), 32'(exp_byte(mem[2], 3)));
    sel = 1'b0;
    @(negedge clk);

    finish_run();
  end
endmodule